// File: doc/BRIEF.md
# Global-Aware Page Translation Cache

This block holds up to 32 recently used linear-to-physical page translations so that a memory pipeline can skip a page-table walk. Each linear page number picks exactly one entry from its own low bits: three bits choose one of eight sets and two more bits choose one of four slots inside that set. Because the slot is fixed by the address, there is no associative search and no victim choice. The buffer behaves as a direct-mapped array of 32 entries, each holding a valid flag, a global flag, a 15-bit tag and a 20-bit physical frame number.

A lookup is purely combinational on the stored array and returns a hit flag and the physical address. After a walk, the walker writes the page number, frame and global attribute through the update port. Software-driven maintenance has two forms: a flush, which either empties the whole array or spares entries marked global, and a single-page invalidate, which drops one entry only when it really holds the named page. All writes take effect at the next rising clock edge.

Top module: `xlat_cache`

## Requirements
- R1: The entry index is linear-address bits 16:12 (bits 14:12 pick the set, bits 16:15 the slot); the stored tag is bits 31:17, and a lookup hits only when the indexed entry is valid and its tag equals lk_addr bits 31:17.
- R2: On a hit, lk_paddr is the stored 20-bit frame in bits 31:12 joined with lk_addr bits 11:0; on a miss lk_paddr is zero.
- R3: An update overwrites the entry indexed by upd_vpn (bits 4:0 of the page number) whatever it held, marks it valid and stores the tag (page-number bits 19:5) and upd_frame; it is visible to lookups after the next rising edge.
- R4: With parameter GLOBAL_EN at 1 the entry's global flag is taken from upd_global; with GLOBAL_EN at 0 no entry is ever global.
- R5: A flush with flush_all at 1 invalidates every entry.
- R6: A flush with flush_all at 0 invalidates every entry except those whose global flag is set.
- R7: An invalidate clears the entry indexed by inv_vpn only when that entry is valid and its tag equals inv_vpn bits 19:5; any other entry, including one at the same index holding a different page, is untouched.
- R8: When flush_req is high, an update or invalidate in the same cycle is discarded.
- R9: When an update and an invalidate name the same index in the same cycle without a flush, the update wins and the entry ends valid with the new contents.
- R10: Reset (rst_n low) clears every valid and global flag.
- R11: lk_hit and lk_paddr follow lk_addr combinationally with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_addr | input | 32 | Linear address to translate |
| lk_hit | output | 1 | Translation present |
| lk_paddr | output | 32 | Physical address, zero on miss |
| upd_en | input | 1 | Write a translation this cycle |
| upd_vpn | input | 20 | Linear page number (address bits 31:12) to fill |
| upd_frame | input | 20 | Physical frame number to store |
| upd_global | input | 1 | Global attribute of the new translation |
| inv_en | input | 1 | Invalidate one page this cycle |
| inv_vpn | input | 20 | Linear page number to invalidate |
| flush_req | input | 1 | Flush request |
| flush_all | input | 1 | 1 = drop everything, 0 = spare global entries |

## Verification
The two functions that can meet in one cycle are the flush and the fill (and, in a second variant, the flush and the single-page invalidate). The bench raises flush_req together with upd_en for a page that was never present, then looks the page up after the edge and expects a miss; it also raises a keep-globals flush together with an invalidate of a global page and expects that page to still hit. A separate case drives an update and an invalidate to the same index in one cycle and expects the freshly written frame to be returned.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int LA_W    = 32;
    localparam int OFS_W   = 12;
    localparam int SET_W   = 3;
    localparam int SLOT_W  = 2;
    localparam int IDX_W   = SET_W + SLOT_W;
    localparam int VPN_W   = LA_W - OFS_W;
    localparam int TAG_W   = VPN_W - IDX_W;
    localparam int FRAME_W = LA_W - OFS_W;
    localparam int N_ENT   = 1 << IDX_W;

    typedef logic [IDX_W-1:0]   idx_t;
    typedef logic [TAG_W-1:0]   tag_t;
    typedef logic [VPN_W-1:0]   vpn_t;
    typedef logic [FRAME_W-1:0] frame_t;

    typedef struct packed {
        logic   vld;
        logic   glb;
        tag_t   tag;
        frame_t frame;
    } entry_t;
endpackage

// File: rtl/xlat_split.sv
module xlat_split
    import xlat_pkg::*;
(
    input  vpn_t vpn,
    output idx_t idx,
    output tag_t tag
);
    // low page-number bits select set (lower) and slot (upper)
    assign idx = vpn[IDX_W-1:0];
    assign tag = vpn[VPN_W-1:IDX_W];
endmodule

// File: rtl/xlat_store.sv
module xlat_store
    import xlat_pkg::*;
#(
    parameter bit GLOBAL_EN = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd_en,
    input  idx_t                 upd_idx,
    input  tag_t                 upd_tag,
    input  frame_t               upd_frame,
    input  logic                 upd_global,
    input  logic                 inv_en,
    input  idx_t                 inv_idx,
    input  tag_t                 inv_tag,
    input  logic                 flush_req,
    input  logic                 flush_all,
    output entry_t [N_ENT-1:0]   ent_o
);
    typedef struct packed {
        entry_t [N_ENT-1:0] ent;
    } state_t;

    state_t st_d, st_q;
    entry_t fill_w;

    always_comb begin
        fill_w.vld   = 1'b1;
        fill_w.glb   = GLOBAL_EN & upd_global;
        fill_w.tag   = upd_tag;
        fill_w.frame = upd_frame;
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_ENT; i++) begin
            if (flush_req) begin
                if (flush_all || !st_q.ent[i].glb) begin
                    st_d.ent[i].vld = 1'b0;
                end
            end else begin
                if (inv_en && (inv_idx == idx_t'(i)) && st_q.ent[i].vld &&
                    (st_q.ent[i].tag == inv_tag)) begin
                    st_d.ent[i].vld = 1'b0;
                end
                if (upd_en && (upd_idx == idx_t'(i))) begin
                    st_d.ent[i] = fill_w;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ent_o = st_q.ent;
endmodule

// File: rtl/xlat_read.sv
module xlat_read
    import xlat_pkg::*;
(
    input  entry_t [N_ENT-1:0]   ent_i,
    input  idx_t                 idx,
    input  tag_t                 tag,
    input  logic [OFS_W-1:0]     ofs,
    output logic                 hit,
    output logic [LA_W-1:0]      paddr
);
    entry_t sel;

    always_comb begin
        sel   = ent_i[idx];
        hit   = sel.vld && (sel.tag == tag);
        paddr = hit ? {sel.frame, ofs} : '0;
    end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter bit GLOBAL_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LA_W-1:0]   lk_addr,
    output logic              lk_hit,
    output logic [LA_W-1:0]   lk_paddr,
    input  logic              upd_en,
    input  logic [VPN_W-1:0]  upd_vpn,
    input  logic [FRAME_W-1:0] upd_frame,
    input  logic              upd_global,
    input  logic              inv_en,
    input  logic [VPN_W-1:0]  inv_vpn,
    input  logic              flush_req,
    input  logic              flush_all
);
    localparam int N_PORT = 3; // lookup, update, invalidate

    vpn_t port_vpn [N_PORT];
    idx_t port_idx [N_PORT];
    tag_t port_tag [N_PORT];

    assign port_vpn[0] = lk_addr[LA_W-1:OFS_W];
    assign port_vpn[1] = upd_vpn;
    assign port_vpn[2] = inv_vpn;

    for (genvar p = 0; p < N_PORT; p++) begin : g_split
        xlat_split u_split (
            .vpn (port_vpn[p]),
            .idx (port_idx[p]),
            .tag (port_tag[p])
        );
    end

    entry_t [N_ENT-1:0] ent_w;

    xlat_store #(.GLOBAL_EN(GLOBAL_EN)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_en     (upd_en),
        .upd_idx    (port_idx[1]),
        .upd_tag    (port_tag[1]),
        .upd_frame  (upd_frame),
        .upd_global (upd_global),
        .inv_en     (inv_en),
        .inv_idx    (port_idx[2]),
        .inv_tag    (port_tag[2]),
        .flush_req  (flush_req),
        .flush_all  (flush_all),
        .ent_o      (ent_w)
    );

    xlat_read u_read (
        .ent_i (ent_w),
        .idx   (port_idx[0]),
        .tag   (port_tag[0]),
        .ofs   (lk_addr[OFS_W-1:0]),
        .hit   (lk_hit),
        .paddr (lk_paddr)
    );
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk
    import xlat_pkg::*;
#(
    parameter bit GLOBAL_EN = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [LA_W-1:0]    lk_addr,
    input logic               lk_hit,
    input logic [LA_W-1:0]    lk_paddr,
    input logic               upd_en,
    input logic [VPN_W-1:0]   upd_vpn,
    input logic [FRAME_W-1:0] upd_frame,
    input logic               inv_en,
    input logic [VPN_W-1:0]   inv_vpn,
    input logic               flush_req,
    input logic               flush_all
);
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_paddr == '0)); // R2

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[OFS_W-1:0] == lk_addr[OFS_W-1:0])); // R2

    AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !flush_req) |=>
        ((lk_addr[LA_W-1:OFS_W] != $past(upd_vpn)) ||
         (lk_hit && (lk_paddr[LA_W-1:OFS_W] == $past(upd_frame))))); // R3

    AST_INVAL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && !flush_req &&
         !(upd_en && (upd_vpn[IDX_W-1:0] == inv_vpn[IDX_W-1:0]))) |=>
        ((lk_addr[LA_W-1:OFS_W] != $past(inv_vpn)) || !lk_hit)); // R7

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && (flush_all || !GLOBAL_EN)) |=> !lk_hit); // R5

    AST_FLUSH_BEATS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && upd_en && (flush_all || !GLOBAL_EN)) |=>
        !(lk_hit && (lk_addr[LA_W-1:OFS_W] == $past(upd_vpn)))); // R8
endmodule

bind xlat_cache xlat_cache_chk #(.GLOBAL_EN(GLOBAL_EN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_addr   (lk_addr),
    .lk_hit    (lk_hit),
    .lk_paddr  (lk_paddr),
    .upd_en    (upd_en),
    .upd_vpn   (upd_vpn),
    .upd_frame (upd_frame),
    .inv_en    (inv_en),
    .inv_vpn   (inv_vpn),
    .flush_req (flush_req),
    .flush_all (flush_all)
);

// File: tb/xlat_cache_bench.sv
module xlat_cache_bench;
    localparam int CLK_P = 10;

    localparam logic [2:0] OP_NONE = 3'd0;
    localparam logic [2:0] OP_UPD  = 3'd1;
    localparam logic [2:0] OP_INV  = 3'd2;
    localparam logic [2:0] OP_FLK  = 3'd3; // flush, spare globals
    localparam logic [2:0] OP_FLA  = 3'd4; // flush everything

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] addr;
        logic [19:0] frame;
        logic        glb;
        logic [31:0] look;
        logic        exp_hit;
        logic [31:0] exp_pa;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [0:NV-1] = '{
        '{OP_UPD,  32'h1234_5678, 20'hABCDE, 1'b0, 32'h1234_5FFF, 1'b1, 32'hABCD_EFFF, 8'd3},  // R3 R2
        '{OP_NONE, 32'h0,         20'h0,     1'b0, 32'h1235_5678, 1'b0, 32'h0,         8'd1},  // R1 slot bit
        '{OP_NONE, 32'h0,         20'h0,     1'b0, 32'h1236_5678, 1'b0, 32'h0,         8'd1},  // R1 tag mismatch
        '{OP_UPD,  32'h0000_7000, 20'h55555, 1'b1, 32'h0000_7000, 1'b1, 32'h5555_5000, 8'd3},  // R3
        '{OP_UPD,  32'h0001_F000, 20'h11111, 1'b0, 32'h0001_F0AB, 1'b1, 32'h1111_10AB, 8'd1},  // R1 top index
        '{OP_FLK,  32'h0,         20'h0,     1'b0, 32'h0000_7123, 1'b1, 32'h5555_5123, 8'd6},  // R6 global kept
        '{OP_NONE, 32'h0,         20'h0,     1'b0, 32'h1234_5678, 1'b0, 32'h0,         8'd6},  // R6
        '{OP_NONE, 32'h0,         20'h0,     1'b0, 32'h0001_F000, 1'b0, 32'h0,         8'd6},  // R6
        '{OP_UPD,  32'h1234_5000, 20'h22222, 1'b0, 32'h1234_5678, 1'b1, 32'h2222_2678, 8'd3},  // R3
        '{OP_INV,  32'h1236_5000, 20'h0,     1'b0, 32'h1234_5678, 1'b1, 32'h2222_2678, 8'd7},  // R7 tag differs
        '{OP_INV,  32'h1234_5000, 20'h0,     1'b0, 32'h1234_5678, 1'b0, 32'h0,         8'd7},  // R7
        '{OP_UPD,  32'h8000_7000, 20'h33333, 1'b0, 32'h8000_7004, 1'b1, 32'h3333_3004, 8'd3},  // R3 overwrite
        '{OP_NONE, 32'h0,         20'h0,     1'b0, 32'h0000_7000, 1'b0, 32'h0,         8'd3},  // R3 evicted
        '{OP_UPD,  32'h0000_7000, 20'h55555, 1'b1, 32'h0000_7000, 1'b1, 32'h5555_5000, 8'd4},  // R4
        '{OP_FLA,  32'h0,         20'h0,     1'b0, 32'h0000_7000, 1'b0, 32'h0,         8'd5}   // R5
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        upd_en = 1'b0;
    logic [19:0] upd_vpn = '0;
    logic [19:0] upd_frame = '0;
    logic        upd_global = 1'b0;
    logic        inv_en = 1'b0;
    logic [19:0] inv_vpn = '0;
    logic        flush_req = 1'b0;
    logic        flush_all = 1'b0;
    logic        lk_hit, lk_hit_ng;
    logic [31:0] lk_paddr, lk_paddr_ng;

    int checks = 0;
    int fails  = 0;

    always #(CLK_P/2) clk = ~clk;

    xlat_cache #(.GLOBAL_EN(1'b1)) u_xlat_cache (
        .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_paddr(lk_paddr),
        .upd_en(upd_en), .upd_vpn(upd_vpn), .upd_frame(upd_frame), .upd_global(upd_global),
        .inv_en(inv_en), .inv_vpn(inv_vpn), .flush_req(flush_req), .flush_all(flush_all)
    );

    xlat_cache #(.GLOBAL_EN(1'b0)) u_xlat_cache_ng (
        .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_hit(lk_hit_ng), .lk_paddr(lk_paddr_ng),
        .upd_en(upd_en), .upd_vpn(upd_vpn), .upd_frame(upd_frame), .upd_global(upd_global),
        .inv_en(inv_en), .inv_vpn(inv_vpn), .flush_req(flush_req), .flush_all(flush_all)
    );

    task automatic check(input string tag, input logic got_hit, input logic [31:0] got_pa,
                         input logic exp_hit, input logic [31:0] exp_pa);
        checks++;
        if (got_hit !== exp_hit || got_pa !== exp_pa) begin
            fails++;
            $display("FAIL %s: hit=%0b paddr=%h expected hit=%0b paddr=%h",
                     tag, got_hit, got_pa, exp_hit, exp_pa);
        end
    endtask

    // drive one operation for exactly one rising edge
    task automatic apply(input logic [2:0] op, input logic [31:0] addr,
                         input logic [19:0] frame, input logic glb);
        @(negedge clk);
        upd_en     = (op == OP_UPD);
        upd_vpn    = addr[31:12];
        upd_frame  = frame;
        upd_global = glb;
        inv_en     = (op == OP_INV);
        inv_vpn    = addr[31:12];
        flush_req  = (op == OP_FLK) || (op == OP_FLA);
        flush_all  = (op == OP_FLA);
        @(negedge clk);
        upd_en = 1'b0; inv_en = 1'b0; flush_req = 1'b0; flush_all = 1'b0;
    endtask

    task automatic look(input logic [31:0] a);
        lk_addr = a;
        #1;
    endtask

    initial begin
        #(CLK_P * 20000);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: everything empty after reset
        look(32'h1234_5678); check("R10 reset empty A", lk_hit, lk_paddr, 1'b0, 32'h0);
        look(32'h0000_7000); check("R10 reset empty B", lk_hit, lk_paddr, 1'b0, 32'h0);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].op, VECS[i].addr, VECS[i].frame, VECS[i].glb);
            look(VECS[i].look);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), lk_hit, lk_paddr,
                  VECS[i].exp_hit, VECS[i].exp_pa);
        end

        // R4: without the global option a keep-globals flush drops a global fill
        apply(OP_UPD, 32'h0000_7000, 20'h55555, 1'b1);
        apply(OP_FLK, 32'h0, 20'h0, 1'b0);
        look(32'h0000_7000);
        check("R4 global variant keeps", lk_hit, lk_paddr, 1'b1, 32'h5555_5000);
        check("R4 no-global variant drops", lk_hit_ng, lk_paddr_ng, 1'b0, 32'h0);

        // R8: fill and flush in the same cycle, flush wins
        @(negedge clk);
        upd_en = 1'b1; upd_vpn = 20'h00003; upd_frame = 20'h44444; upd_global = 1'b0;
        flush_req = 1'b1; flush_all = 1'b0;
        @(negedge clk);
        upd_en = 1'b0; flush_req = 1'b0;
        look(32'h0000_3000);
        check("R8 flush beats fill", lk_hit, lk_paddr, 1'b0, 32'h0);

        // R8: invalidate of a global page during a keep-globals flush is ignored
        apply(OP_UPD, 32'h0000_A000, 20'h9ABCD, 1'b1);
        @(negedge clk);
        inv_en = 1'b1; inv_vpn = 20'h0000A; flush_req = 1'b1; flush_all = 1'b0;
        @(negedge clk);
        inv_en = 1'b0; flush_req = 1'b0;
        look(32'h0000_A010);
        check("R8 flush beats invalidate", lk_hit, lk_paddr, 1'b1, 32'h9ABC_D010);

        // R9: fill and invalidate of the same page in one cycle, fill wins
        apply(OP_UPD, 32'h0004_2000, 20'h66666, 1'b0);
        @(negedge clk);
        upd_en = 1'b1; upd_vpn = 20'h00042; upd_frame = 20'h77777; upd_global = 1'b0;
        inv_en = 1'b1; inv_vpn = 20'h00042;
        @(negedge clk);
        upd_en = 1'b0; inv_en = 1'b0;
        look(32'h0004_2ABC);
        check("R9 fill beats invalidate", lk_hit, lk_paddr, 1'b1, 32'h7777_7ABC);

        // R11: two lookups inside one low phase, no edge in between
        look(32'h0000_A001);
        check("R11 comb lookup first", lk_hit, lk_paddr, 1'b1, 32'h9ABC_D001);
        look(32'h0004_2002);
        check("R11 comb lookup second", lk_hit, lk_paddr, 1'b1, 32'h7777_7002);

        // R10: reset in mid-run clears global entries too
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        look(32'h0000_A001);
        check("R10 reset clears global", lk_hit, lk_paddr, 1'b0, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule